// File: doc/BRIEF.md
# Asynchronous Bus Slave Responder

This block sits on the peripheral side of an asynchronous, strobe-handshaked parallel bus. It watches the address strobe, the data strobe, the read/write line, a two-bit transfer size code and the address. When both strobes are asserted (low) and the address falls inside its own window, it serves the transfer from a small byte-wide internal register file. It answers on the two active-low data-size acknowledge lines, and the code it puts there tells the master how wide the port is.

The port width is fixed by a parameter at 8 or 16 bits. A second parameter holds off the acknowledge for a number of clock cycles, which emulates a slow device. The responder drives the data bus and the acknowledge lines only while it is selected. It keeps both driven until the master has negated the strobes, and releases them on the next clock edge. It does not take a new transfer until the strobes have been seen negated.

Top module: `async_bus_responder`

## Requirements
- R1: The responder is selected only when `as_n` and `ds_n` are both low and `addr[23:AW]` equals `BASE_ADDR[23:AW]`. When it is not selected, `data` and `dsack_n` are left undriven (high impedance).
- R2: On a 16-bit port, a read drives all of `data[15:0]`. The byte at the even address `{addr[AW-1:1],0}` goes on `data[15:8]` and the odd byte on `data[7:0]`, for both byte and word sizes.
- R3: On an 8-bit port, a read drives the byte at `addr[AW-1:0]` on `data[15:8]` and leaves `data[7:0]` undriven.
- R4: The acknowledge code is `dsack_n = 2'b01` for a 16-bit port and `2'b10` for an 8-bit port. No other low code is ever driven.
- R5: After the clock edge that first sees the responder selected, `dsack_n` is driven `2'b11` for `WAIT_STATES` further edges. The acknowledge code appears after edge number `WAIT_STATES+1`.
- R6: A write to a 16-bit port is captured on the edge where the acknowledge is asserted. Size code `siz = 2'b01` is a byte transfer: `addr[0] = 0` writes the even byte from `data[15:8]`, and `addr[0] = 1` writes the odd byte from `data[7:0]`. Any other size code writes both bytes.
- R7: A write to an 8-bit port stores `data[15:8]` at `addr[AW-1:0]`, whatever the size code.
- R8: The acknowledge code and the read data stay driven for as long as either strobe stays low. Both are released on the first edge that sees both strobes high.
- R9: A new transfer is accepted only from the idle state, which is reached only after the strobes have been seen negated. Holding the strobes low after an acknowledge never starts a second transfer.
- R10: Reset (`rst_n` low) releases the bus and clears every register file byte to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Responder clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| siz | input | 2 | Transfer size code, 01 = byte |
| addr | input | 24 | Byte address |
| data | inout | 16 | Bidirectional data bus |
| dsack_n | inout | 2 | Active-low data-size acknowledge |

## Verification
The bench counts falling clock edges from the one at which it asserts the strobes. The acknowledge and the read data are due at falling edge `WAIT_STATES+2`. Before that edge `dsack_n` must read `11`, and from that edge until the strobes rise it must hold the port's code. Release is checked one falling edge after the strobes are negated, because one register edge lies in between. Two instances, a 16-bit port with two wait states and an 8-bit port with none, share the strobes, so each latency is checked against its own due edge.

// File: rtl/async_bus_responder.sv
module async_bus_responder #(
  parameter logic [23:0] BASE_ADDR   = 24'h00F000,
  parameter int          AW          = 4,
  parameter int          PORT_WIDTH  = 16,
  parameter int          WAIT_STATES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        as_n,
  input  logic        ds_n,
  input  logic        rw,
  input  logic [1:0]  siz,
  input  logic [23:0] addr,
  inout  wire  [15:0] data,
  inout  wire  [1:0]  dsack_n
);
  localparam int NB = 1 << AW;
  localparam int CW = (WAIT_STATES > 0) ? $clog2(WAIT_STATES + 1) : 1;
  localparam logic [1:0] ACK_CODE = (PORT_WIDTH == 8) ? 2'b10 : 2'b01;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_ACK} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic [7:0] mem [NB];

  wire hit      = (addr[23:AW] == BASE_ADDR[23:AW]);
  wire sel      = !as_n && !ds_n && hit;
  wire strb_off = as_n && ds_n;
  wire go_ack   = (st == S_WAIT) && !strb_off && (cnt == '0);
  wire [AW-1:0] ba   = addr[AW-1:0];
  wire [AW-1:0] even = {ba[AW-1:1], 1'b0};
  wire [AW-1:0] odd  = {ba[AW-1:1], 1'b1};
  wire drive_rd = (st == S_ACK) && rw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (sel) begin
          st  <= S_WAIT;
          cnt <= CW'(WAIT_STATES);
        end
        S_WAIT: begin
          if (strb_off)         st  <= S_IDLE;
          else if (cnt == '0)   st  <= S_ACK;
          else                  cnt <= cnt - 1'b1;
        end
        S_ACK: if (strb_off) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign dsack_n = (st == S_IDLE) ? 2'bzz : ((st == S_ACK) ? ACK_CODE : 2'b11);

  generate
    if (PORT_WIDTH == 8) begin : g_p8
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < NB; i++) mem[i] <= 8'h00;
        end else if (go_ack && !rw) begin
          mem[ba] <= data[15:8];
        end
      end
      assign data[15:8] = drive_rd ? mem[ba] : 8'hzz;
      assign data[7:0]  = 8'hzz;
    end else begin : g_p16
      wire byte_xfer = (siz == 2'b01);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < NB; i++) mem[i] <= 8'h00;
        end else if (go_ack && !rw) begin
          if (!byte_xfer || !ba[0]) mem[even] <= data[15:8];
          if (!byte_xfer ||  ba[0]) mem[odd]  <= data[7:0];
        end
      end
      assign data = drive_rd ? {mem[even], mem[odd]} : 16'hzzzz;
    end
  endgenerate

  // R8
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACK && !strb_off) |=> (st == S_ACK));
  // R8
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACK && strb_off) |=> (st == S_IDLE));
  // R5
  wait_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && !strb_off && cnt != '0) |=> (st == S_WAIT && cnt == $past(cnt) - 1'b1));
  // R5
  ack_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == S_ACK) |-> ($past(st) == S_WAIT && $past(cnt) == '0));
  // R9
  no_reentry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACK) |=> (st != S_WAIT));
  // R1
  select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !sel) |=> (st == S_IDLE));
endmodule

// File: tb/async_bus_responder_test.sv
module async_bus_responder_test;
  localparam logic [23:0] BASE = 24'h00F000;
  localparam int LAT16 = 2 + 2;
  localparam int LAT8  = 0 + 2;

  logic clk = 1'b0;
  logic rst_n, as_n, ds_n, rw;
  logic [1:0] siz;
  logic [23:0] addr;
  logic [15:0] m_d16, m_d8;
  logic m_oe;
  wire [15:0] data16, data8;
  wire [1:0] dsack16, dsack8;

  pullup (data16[0]);  pullup (data16[1]);  pullup (data16[2]);  pullup (data16[3]);
  pullup (data16[4]);  pullup (data16[5]);  pullup (data16[6]);  pullup (data16[7]);
  pullup (data16[8]);  pullup (data16[9]);  pullup (data16[10]); pullup (data16[11]);
  pullup (data16[12]); pullup (data16[13]); pullup (data16[14]); pullup (data16[15]);
  pullup (data8[0]);   pullup (data8[1]);   pullup (data8[2]);   pullup (data8[3]);
  pullup (data8[4]);   pullup (data8[5]);   pullup (data8[6]);   pullup (data8[7]);
  pullup (data8[8]);   pullup (data8[9]);   pullup (data8[10]);  pullup (data8[11]);
  pullup (data8[12]);  pullup (data8[13]);  pullup (data8[14]);  pullup (data8[15]);
  pullup (dsack16[0]); pullup (dsack16[1]); pullup (dsack8[0]);  pullup (dsack8[1]);

  assign data16 = m_oe ? m_d16 : 16'hzzzz;
  assign data8  = m_oe ? m_d8  : 16'hzzzz;

  always #2.5 clk = ~clk;

  async_bus_responder #(.BASE_ADDR(BASE), .AW(4), .PORT_WIDTH(16), .WAIT_STATES(2)) uut (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .ds_n(ds_n), .rw(rw), .siz(siz),
    .addr(addr), .data(data16), .dsack_n(dsack16));
  async_bus_responder #(.BASE_ADDR(BASE), .AW(4), .PORT_WIDTH(8), .WAIT_STATES(0)) uut8 (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .ds_n(ds_n), .rw(rw), .siz(siz),
    .addr(addr), .data(data8), .dsack_n(dsack8));

  typedef struct { logic rd; logic [15:0] d; string tag; } item_t;
  item_t q16[$];
  item_t q8[$];
  int n_chk = 0, n_fail = 0;
  logic cyc_on = 1'b0, done16 = 1'b0, done8 = 1'b0;
  int cnt = 0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always begin
    @(negedge clk); #1;
    if (!cyc_on) begin
      cnt = 0; done16 = 1'b0; done8 = 1'b0;
    end else begin
      if (!done16) begin
        if (dsack16 == 2'b01) begin
          item_t it = q16.pop_front();
          chk(cnt == LAT16, "R5 16-bit latency", cnt, LAT16);
          if (it.rd) chk(data16 == it.d, it.tag, data16, it.d);
          done16 = 1'b1;
        end else if (dsack16 != 2'b11) chk(1'b0, "R4 16-bit code", dsack16, 2'b01);
      end else chk(dsack16 == 2'b01, "R8 16-bit hold", dsack16, 2'b01);
      if (!done8) begin
        if (dsack8 == 2'b10) begin
          item_t it = q8.pop_front();
          chk(cnt == LAT8, "R5 8-bit latency", cnt, LAT8);
          if (it.rd) begin
            chk(data8[15:8] == it.d[15:8], it.tag, data8[15:8], it.d[15:8]);
            chk(data8[7:0] == 8'hFF, "R3 lower byte released", data8[7:0], 8'hFF);
          end
          done8 = 1'b1;
        end else if (dsack8 != 2'b11) chk(1'b0, "R4 8-bit code", dsack8, 2'b10);
      end else chk(dsack8 == 2'b10, "R8 8-bit hold", dsack8, 2'b10);
      cnt++;
    end
  end

  task automatic bus_cyc(input logic r, input logic [23:0] a, input logic [1:0] s,
                         input logic [15:0] w16, input logic [7:0] w8,
                         input logic [15:0] e16, input logic [7:0] e8,
                         input int hold, input string tag);
    @(negedge clk);
    rw = r; addr = a; siz = s; m_d16 = w16; m_d8 = {w8, 8'h00}; m_oe = !r;
    as_n = 1'b0; ds_n = 1'b0; cyc_on = 1'b1;
    q16.push_back('{r, e16, tag});
    q8.push_back('{r, {e8, 8'hFF}, tag});
    for (int i = 0; i < 30 && !(done16 && done8); i++) @(negedge clk);
    if (!(done16 && done8)) begin
      chk(1'b0, "R5 acknowledge timeout", {done16, done8}, 2'b11);
      q16.delete(); q8.delete();
    end
    repeat (hold) @(negedge clk);
    @(negedge clk);
    as_n = 1'b1; ds_n = 1'b1; m_oe = 1'b0; cyc_on = 1'b0;
    @(negedge clk); #1;
    chk(dsack16 == 2'b11 && dsack8 == 2'b11, "R8 acknowledge release", {dsack16, dsack8}, 4'hF);
    chk(data16 == 16'hFFFF && data8 == 16'hFFFF, "R8 data release", {data16, data8}, 32'hFFFFFFFF);
  endtask

  initial begin
    rst_n = 1'b0; as_n = 1'b1; ds_n = 1'b1; rw = 1'b1; siz = 2'b10; addr = '0;
    m_d16 = '0; m_d8 = '0; m_oe = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(dsack16 == 2'b11 && dsack8 == 2'b11, "R10 reset acknowledge released", {dsack16, dsack8}, 4'hF);
    chk(data16 == 16'hFFFF && data8 == 16'hFFFF, "R10 reset data released", {data16, data8}, 32'hFFFFFFFF);
    @(negedge clk); rst_n = 1'b1;

    bus_cyc(1'b1, BASE + 24'd0, 2'b10, 16'h0, 8'h0, 16'h0000, 8'h00, 0, "R10 cleared byte");
    bus_cyc(1'b0, BASE + 24'd2, 2'b10, 16'hA1B2, 8'hA1, 16'h0, 8'h0, 0, "R6 word write");
    bus_cyc(1'b0, BASE + 24'd5, 2'b01, 16'h5C5C, 8'h5C, 16'h0, 8'h0, 0, "R6 odd byte write");
    bus_cyc(1'b0, BASE + 24'd4, 2'b01, 16'h3D3D, 8'h3D, 16'h0, 8'h0, 0, "R6 even byte write");
    bus_cyc(1'b0, BASE + 24'd6, 2'b01, 16'hE499, 8'hE4, 16'h0, 8'h0, 0, "R7 byte write");
    bus_cyc(1'b1, BASE + 24'd2, 2'b10, 16'h0, 8'h0, 16'hA1B2, 8'hA1, 0, "R2 R6 R7 word read");
    bus_cyc(1'b1, BASE + 24'd4, 2'b10, 16'h0, 8'h0, 16'h3D5C, 8'h3D, 0, "R2 R6 byte merge");
    bus_cyc(1'b1, BASE + 24'd6, 2'b10, 16'h0, 8'h0, 16'hE400, 8'hE4, 0, "R6 odd byte untouched");
    bus_cyc(1'b1, BASE + 24'd5, 2'b01, 16'h0, 8'h0, 16'h3D5C, 8'h5C, 0, "R2 R3 byte read");
    bus_cyc(1'b1, BASE + 24'd3, 2'b01, 16'h0, 8'h0, 16'hA1B2, 8'h00, 0, "R3 R7 unwritten byte");
    bus_cyc(1'b1, BASE + 24'd2, 2'b10, 16'h0, 8'h0, 16'hA1B2, 8'hA1, 6, "R8 R9 held strobes");

    @(negedge clk);
    rw = 1'b1; addr = BASE + 24'h10; siz = 2'b10; as_n = 1'b0; ds_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1;
      chk(dsack16 == 2'b11 && dsack8 == 2'b11, "R1 outside window no acknowledge", {dsack16, dsack8}, 4'hF);
      chk(data16 == 16'hFFFF && data8 == 16'hFFFF, "R1 outside window no data", {data16, data8}, 32'hFFFFFFFF);
    end
    as_n = 1'b1; ds_n = 1'b1;
    bus_cyc(1'b1, BASE + 24'd4, 2'b10, 16'h0, 8'h0, 16'h3D5C, 8'h3D, 0, "R1 R9 select after miss");

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule